// File: doc/BRIEF.md
# Constant-On-Time Pulse Controller

This block produces the high-side on-pulse for a two-phase buck regulator that uses constant-on-time control. It does not run from a fixed switching clock. A cycle starts when a digital valley flag reports that the output has dropped to its reference. The selected phase's pulse then stays high for a programmed number of clock cycles. After the pulse, a minimum off window must pass before another cycle can start.

Several other digital flags shape when and where a cycle happens. A valley current-limit flag can veto a start. A per-phase "hotter than average" flag shortens that phase's on-count by a programmed trim step. A mode input selects between alternating two-phase operation and single-phase operation. Every analog quantity reaches the block as a flag or a register value. The count for each cycle is fixed at the edge where that cycle starts.

Top module: `cot_pulse_ctrl`

## Requirements
- R1: While `rst_n` is low, both `hs_on` bits are 0. After reset, the first cycle in two-phase mode uses phase 0 (`hs_on[0]`).
- R2: A cycle starts on the rising clock edge at which `enable` = 1, `valley_trig` = 1 and `ilim_valley` = 0 are sampled while the block is idle. `hs_on` of the selected phase goes high at that edge. With no valley flag, no cycle starts.
- R3: After a pulse ends, `hs_on` stays all-zero for at least MIN_OFF_CYC (30) cycles. If the valley flag is held high, the next pulse rises after exactly MIN_OFF_CYC+1 low cycles.
- R4: A pulse is never shorter than MIN_ON_CYC (7) cycles. An on-count below that limit yields a pulse of exactly MIN_ON_CYC cycles.
- R5: In two-phase mode, if `hot_ph[p]` = 1 when phase p starts a cycle, the pulse lasts max(`ton_count` − `trim_step`, MIN_ON_CYC) cycles. Otherwise it lasts max(`ton_count`, MIN_ON_CYC) cycles.
- R6: In two-phase mode (`two_phase` = 1), each new cycle uses the phase opposite to the phase that was pulsed last.
- R7: In one-phase mode (`two_phase` = 0), only `hs_on[0]` is ever pulsed. The following two-phase cycle then uses phase 1.
- R8: In one-phase mode, `hot_ph` has no effect, and the pulse lasts max(`ton_count`, MIN_ON_CYC) cycles.
- R9: While `ilim_valley` = 1, no cycle starts even if `valley_trig` = 1. The start happens on the first edge at which the flag is sampled low.
- R10: When `enable` is sampled low, `hs_on` is all-zero after that edge and the block returns to idle. The next cycle after `enable` returns uses phase 0.
- R11: At most one bit of `hs_on` is high at any time.
- R12: `ton_count`, `trim_step` and `hot_ph` are sampled only at the cycle start. Changing them during a pulse does not change that pulse's width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low aborts any pulse and returns to idle |
| valley_trig | input | 1 | Valley comparator flag: output at or below reference |
| ilim_valley | input | 1 | Valley current-limit flag; vetoes a cycle start |
| two_phase | input | 1 | 1 = alternate both phases, 0 = phase 0 only |
| hot_ph | input | 2 | Per-phase flag: phase current above the active average |
| ton_count | input | CNT_W | Programmed on-time in clock cycles |
| trim_step | input | CNT_W | Cycles removed from a hot phase's on-time |
| hs_on | output | 2 | High-side on-pulse, bit p for phase p |

## Verification
Directed runs hold the valley flag high in each mode.

- Held valley, one-phase mode: separates phase alternation from the fixed phase-0 behaviour, and exposes the exact off window between pulses.
- Hot flags with small and large trim steps: distinguish a plain subtraction from the clamped result.
- On-count below the minimum: shows the same clamp without any trim.
- Count changed in the middle of a pulse: shows that the count is captured at the start.
- Current-limit flag held, then released: shows that the start is vetoed and then released one edge later.
- Abort in the middle of a pulse: shows the return to idle and the reset of the phase pointer.

A long seeded random phase then toggles all inputs together and compares `hs_on` each cycle with a cycle-level model built from the requirements.

// File: rtl/cot_pkg.sv
package cot_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ON   = 2'd1,
      ST_OFF  = 2'd2
   } cot_state_t;
endpackage

// File: rtl/cot_ontime_calc.sv
// Computes the on-length of the cycle about to start: programmed count,
// less the balance trim for a hot phase in two-phase mode, floored at the
// minimum pulse width.
module cot_ontime_calc #(
   parameter int CNT_W  = 10,
   parameter int MIN_ON = 7
) (
   input  logic [CNT_W-1:0] ton_count,
   input  logic [CNT_W-1:0] trim_step,
   input  logic             hot,
   input  logic             two_phase,
   output logic [CNT_W-1:0] on_len
);
   localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(MIN_ON);

   logic             trim_apply;
   logic [CNT_W-1:0] trimmed;

   assign trim_apply = hot & two_phase;

   always_comb begin
      trimmed = ton_count;
      if (trim_apply) begin
         if (ton_count > trim_step) trimmed = ton_count - trim_step;
         else                       trimmed = '0;
      end
      on_len = (trimmed < MIN_LEN) ? MIN_LEN : trimmed;
   end
endmodule

// File: rtl/cot_phase_sel.sv
// Phase pointer: two-phase mode alternates, one-phase mode stays on phase 0.
module cot_phase_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic start,
   input  logic two_phase,
   output logic sel_ph
);
   logic next_ph;

   assign sel_ph = two_phase ? next_ph : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       next_ph <= 1'b0;
      else if (!enable) next_ph <= 1'b0;
      else if (start)   next_ph <= ~sel_ph;
   end
endmodule

// File: rtl/cot_timer.sv
// Shared one-shot: one down-counter times the on pulse, then the off window.
module cot_timer
   import cot_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int MIN_OFF = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             req,
   input  logic [CNT_W-1:0] on_len,
   input  logic             sel_ph,
   output logic             start,
   output logic             pulse,
   output logic             cur_ph
);
   localparam logic [CNT_W-1:0] OFF_LOAD = CNT_W'(MIN_OFF - 1);

   cot_state_t       st;
   logic [CNT_W-1:0] cnt;

   assign start = enable && (st == ST_IDLE) && req;
   assign pulse = (st == ST_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         cur_ph <= 1'b0;
      end else if (!enable) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req) begin
                  st     <= ST_ON;
                  cnt    <= on_len - 1'b1;
                  cur_ph <= sel_ph;
               end
            end
            ST_ON: begin
               if (cnt == '0) begin
                  st  <= ST_OFF;
                  cnt <= OFF_LOAD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_OFF: begin
               if (cnt == '0) st <= ST_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cot_pulse_ctrl.sv
module cot_pulse_ctrl #(
   parameter int CNT_W       = 10,
   parameter int MIN_ON_CYC  = 7,
   parameter int MIN_OFF_CYC = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             valley_trig,
   input  logic             ilim_valley,
   input  logic             two_phase,
   input  logic [1:0]       hot_ph,
   input  logic [CNT_W-1:0] ton_count,
   input  logic [CNT_W-1:0] trim_step,
   output logic [1:0]       hs_on
);
   localparam int NPH = 2;

   if (MIN_ON_CYC < 1) begin : g_bad_min_on
      $error("MIN_ON_CYC must be at least 1");
   end
   if (MIN_OFF_CYC < 1) begin : g_bad_min_off
      $error("MIN_OFF_CYC must be at least 1");
   end
   if ((MIN_ON_CYC >= (1 << CNT_W)) || (MIN_OFF_CYC > (1 << CNT_W))) begin : g_bad_width
      $error("CNT_W too narrow for the minimum on/off limits");
   end

   logic             req;
   logic             start;
   logic             pulse;
   logic             cur_ph;
   logic             sel_ph;
   logic             hot_sel;
   logic [CNT_W-1:0] on_len;

   assign req     = valley_trig & ~ilim_valley;
   assign hot_sel = hot_ph[sel_ph];

   cot_phase_sel i_phase_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .start     (start),
      .two_phase (two_phase),
      .sel_ph    (sel_ph)
   );

   cot_ontime_calc #(
      .CNT_W  (CNT_W),
      .MIN_ON (MIN_ON_CYC)
   ) i_ontime (
      .ton_count (ton_count),
      .trim_step (trim_step),
      .hot       (hot_sel),
      .two_phase (two_phase),
      .on_len    (on_len)
   );

   cot_timer #(
      .CNT_W   (CNT_W),
      .MIN_OFF (MIN_OFF_CYC)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .req    (req),
      .on_len (on_len),
      .sel_ph (sel_ph),
      .start  (start),
      .pulse  (pulse),
      .cur_ph (cur_ph)
   );

   for (genvar p = 0; p < NPH; p++) begin : g_phase_out
      assign hs_on[p] = pulse & (cur_ph == 1'(p));
   end
endmodule

// File: rtl/cot_pulse_ctrl_chk.sv
module cot_pulse_ctrl_chk #(
   parameter int MIN_ON_CYC  = 7,
   parameter int MIN_OFF_CYC = 30
) (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       valley_trig,
   input logic       ilim_valley,
   input logic       two_phase,
   input logic [1:0] hs_on
);
   logic [15:0] hi_run;
   logic [15:0] lo_run;
   logic        seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
         seen   <= 1'b0;
      end else begin
         if (|hs_on) begin
            hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1;
            lo_run <= '0;
         end else begin
            lo_run <= (lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1;
            hi_run <= '0;
         end
         if (!enable)     seen <= 1'b0;
         else if (|hs_on) seen <= 1'b1;
      end
   end

   p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hs_on));

   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (hs_on == 2'b00));

   p_veto_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|hs_on) |-> ($past(!ilim_valley) && $past(valley_trig) && $past(enable)));

   p_min_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(|hs_on) && $past(enable)) |-> (hi_run >= 16'(MIN_ON_CYC)));

   p_min_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(|hs_on) && seen) |-> (lo_run >= 16'(MIN_OFF_CYC)));

   p_one_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_on[1]) |-> $past(two_phase));
endmodule

bind cot_pulse_ctrl cot_pulse_ctrl_chk #(
   .MIN_ON_CYC  (MIN_ON_CYC),
   .MIN_OFF_CYC (MIN_OFF_CYC)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .valley_trig (valley_trig),
   .ilim_valley (ilim_valley),
   .two_phase   (two_phase),
   .hs_on       (hs_on)
);

// File: tb/test_cot_pulse_ctrl.sv
module test_cot_pulse_ctrl;
   localparam int CNT_W   = 10;
   localparam int MIN_ON  = 7;
   localparam int MIN_OFF = 30;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic             valley_trig = 1'b0;
   logic             ilim_valley = 1'b0;
   logic             two_phase = 1'b0;
   logic [1:0]       hot_ph = 2'b00;
   logic [CNT_W-1:0] ton_count = CNT_W'(20);
   logic [CNT_W-1:0] trim_step = CNT_W'(5);
   logic [1:0]       hs_on;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   cot_pulse_ctrl #(
      .CNT_W       (CNT_W),
      .MIN_ON_CYC  (MIN_ON),
      .MIN_OFF_CYC (MIN_OFF)
   ) i_cot_pulse_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .valley_trig (valley_trig),
      .ilim_valley (ilim_valley),
      .two_phase   (two_phase),
      .hot_ph      (hot_ph),
      .ton_count   (ton_count),
      .trim_step   (trim_step),
      .hs_on       (hs_on)
   );

   function automatic int exp_len(int ton, int trim, bit hot, bit two);
      int d;
      d = ton;
      if (hot && two) d = ton - trim;
      if (d < MIN_ON) d = MIN_ON;
      return d;
   endfunction

   // cycle-level reference model built from the requirements
   int m_st = 0, m_cnt = 0, m_ph = 0, m_nxt = 0;
   always @(posedge clk) begin
      if (!rst_n || !enable) begin
         m_st <= 0; m_nxt <= 0;
         if (!rst_n) m_ph <= 0;
      end else begin
         case (m_st)
            0: if (valley_trig && !ilim_valley) begin
                  int s;
                  s = two_phase ? m_nxt : 0;
                  m_ph  <= s;
                  m_nxt <= 1 - s;
                  m_cnt <= exp_len(int'(ton_count), int'(trim_step), hot_ph[s], two_phase) - 1;
                  m_st  <= 1;
               end
            1: if (m_cnt == 0) begin m_st <= 2; m_cnt <= MIN_OFF - 1; end
               else m_cnt <= m_cnt - 1;
            default: if (m_cnt == 0) m_st <= 0; else m_cnt <= m_cnt - 1;
         endcase
      end
   end

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int e;
         e = (m_st == 1) ? (1 << m_ph) : 0;
         chk("R2 R6 per-cycle hs_on vs model", int'(hs_on), e);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         fails++; tests++;
         $display("FAIL watchdog R2 actual=%0d expected<100000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // waits for the next pulse; gap counts low cycles including the one
   // consumed by the previous call
   task automatic wait_pulse(output int ph, output int w, output int gap,
                             input int chg_at, input int chg_val);
      int guard;
      gap = 1; ph = -1; w = 0; guard = 0;
      forever begin
         @(negedge clk);
         if (hs_on != 2'b00) break;
         gap++; guard++;
         if (guard > 2000) return;
      end
      ph = hs_on[1] ? 1 : 0;
      w = 1;
      forever begin
         @(negedge clk);
         if (hs_on == 2'b00) break;
         w++;
         if (w == chg_at) ton_count = CNT_W'(chg_val);
      end
   endtask

   initial begin
      int ph, w, gap;
      void'($urandom(32'h00C0_FFEE));
      repeat (3) @(negedge clk);
      chk("R1 hs_on during reset", int'(hs_on), 0);
      rst_n = 1'b1; enable = 1'b1;
      repeat (5) @(negedge clk);
      chk("R2 no start without valley", int'(hs_on), 0);

      // one-phase, held valley
      two_phase = 1'b0; valley_trig = 1'b1;
      wait_pulse(ph, w, gap, -1, 0);
      chk("R7 one-phase phase", ph, 0);
      chk("R2 width", w, 20);
      wait_pulse(ph, w, gap, -1, 0);
      chk("R7 one-phase phase again", ph, 0);
      chk("R3 off gap with held valley", gap, MIN_OFF + 1);
      hot_ph = 2'b01;
      wait_pulse(ph, w, gap, -1, 0);
      chk("R8 hot ignored in one-phase", w, 20);
      valley_trig = 1'b0; hot_ph = 2'b00;
      repeat (40) @(negedge clk);

      // two-phase alternation; last pulse was phase 0
      two_phase = 1'b1; valley_trig = 1'b1;
      wait_pulse(ph, w, gap, -1, 0);
      chk("R7 two-phase follows phase 0 with phase 1", ph, 1);
      wait_pulse(ph, w, gap, -1, 0);
      chk("R6 alternate to phase 0", ph, 0);
      hot_ph = 2'b01;
      wait_pulse(ph, w, gap, -1, 0);
      chk("R6 alternate to phase 1", ph, 1);
      chk("R5 cool phase untrimmed", w, 20);
      wait_pulse(ph, w, gap, -1, 0);
      chk("R5 hot phase trimmed", w, 15);
      trim_step = CNT_W'(18);
      wait_pulse(ph, w, gap, -1, 0);
      chk("R5 phase 1 not hot", w, 20);
      wait_pulse(ph, w, gap, -1, 0);
      chk("R5 trim clamped at minimum", w, MIN_ON);
      hot_ph = 2'b00; trim_step = '0; ton_count = CNT_W'(3);
      wait_pulse(ph, w, gap, -1, 0);
      chk("R4 short count floored", w, MIN_ON);
      ton_count = CNT_W'(20);
      wait_pulse(ph, w, gap, 2, 40);
      chk("R12 mid-pulse change ignored", w, 20);
      wait_pulse(ph, w, gap, -1, 0);
      chk("R12 new count used next cycle", w, 40);
      ton_count = CNT_W'(20);

      // current-limit veto
      valley_trig = 1'b0;
      repeat (40) @(negedge clk);
      ilim_valley = 1'b1; valley_trig = 1'b1;
      begin
         int seen_hi;
         seen_hi = 0;
         repeat (50) begin
            @(negedge clk);
            if (hs_on != 2'b00) seen_hi = 1;
         end
         chk("R9 no start while limit flag set", seen_hi, 0);
      end
      ilim_valley = 1'b0;
      wait_pulse(ph, w, gap, -1, 0);
      chk("R9 start one edge after flag clears", gap, 1);

      // abort
      begin
         int guard;
         guard = 0;
         while (hs_on == 2'b00 && guard < 200) begin @(negedge clk); guard++; end
         repeat (3) @(negedge clk);
         enable = 1'b0;
         @(negedge clk);
         chk("R10 abort clears hs_on", int'(hs_on), 0);
         enable = 1'b1;
      end
      wait_pulse(ph, w, gap, -1, 0);
      chk("R10 pointer back to phase 0", ph, 0);
      chk("R10 width after abort", w, 20);

      // seeded random phase
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         valley_trig = ($urandom % 4) != 0;
         ilim_valley = ($urandom % 10) == 0;
         if (($urandom % 200) == 0) two_phase = ~two_phase;
         hot_ph = 2'($urandom);
         if (($urandom % 40) == 0) ton_count = CNT_W'($urandom % 50);
         trim_step = CNT_W'($urandom % 30);
         enable = ($urandom % 300) != 0;
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule